// File: doc/BRIEF.md
# Configurable CRC Generator and Codeword Checker

This block computes an n-bit cyclic redundancy check over a stream that arrives either one bit or one byte per clock. The generator polynomial, register width, seed value, input and output bit reflection, final XOR mask and byte swapping of the emitted value are all fixed by parameter. The division runs without zero padding: each incoming bit is combined with the register's top bit, and that combination decides whether the polynomial is folded back in. The finished check value therefore appears one clock after the final input beat.

A frame opens with a `start` strobe, which reloads the seed. The strobe may coincide with the first data beat. `last` marks the final beat. To generate a check value, the message alone is fed in and `crc_out` is read when `crc_done` pulses. To check a codeword, the message is fed in with its check value appended in transmission order. On the same pulse, `match` reports whether the finished value (after output reflection and the final XOR, before any byte swap) equals the residue constant given by parameter. That constant is zero when neither a final XOR nor an output reflection is applied.

Top module: `crc_engine`

## Requirements
- R1: The check value is the remainder of the message, read as a GF(2) polynomial with the first bit as the highest power, divided by the generator given in normal form without its top term. With the generator x^3+x+1 (POLY = 3'b011, zero seed, no options), the 14-bit message 11010011101100 gives 3'b100.
- R2: In check mode, a clean codeword (message followed by its check value in transmission order) raises `match` together with `crc_done`. The residue is 3'b000 for the 3-bit code, 16'h0000 for the plain 16-bit code, and 32'h2144DF1C for the reflected 32-bit code with an all-ones final XOR.
- R3: `start` loads the seed PRESET before the beat it accompanies is processed. A `start` without `valid` leaves the register at PRESET. Cycles with neither `start` nor `valid` leave the register unchanged.
- R4: The emitted value is the register, bit-reversed when REFOUT is set, XORed with XOROUT. For the 32-bit code (POLY 32'h04C11DB7, all-ones seed and mask, both reflections), the ASCII string "123456789" yields 32'hCBF43926 before the byte swap.
- R5: With REFIN set, byte beats process bit 0 of `data_in` first. With REFIN clear, they process bit 7 first.
- R6: A byte beat (`byte_en` high) gives the same register as eight single-bit beats (`byte_en` low, bit in `data_in[0]`) presented in the order set by R5.
- R7: With BYTE_SWAP set and WIDTH a multiple of 8, `crc_out` carries the emitted value with its byte order reversed. "123456789" on the 32-bit code then gives 32'h2639F4CB.
- R8: `crc_out` is updated and `crc_done` pulses high for one cycle on the clock after a beat with `valid` and `last`. `crc_out` holds its value in every other cycle, and `match` is never high without `crc_done`.
- R9: Any error burst of length 1 to n bits, at any position in a codeword, clears `match`.
- R10: With a non-zero seed, prefixing a zero byte to a message changes the check value.
- R11: During reset, `crc_out`, `crc_done` and `match` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Reload the seed; may accompany the first beat |
| valid | input | 1 | An input beat is present this cycle |
| byte_en | input | 1 | 1: the beat is the whole `data_in` byte; 0: the beat is the single bit `data_in[0]` |
| data_in | input | 8 | Input data |
| last | input | 1 | Qualifies the final beat of a frame when `valid` is high |
| crc_out | output | WIDTH | Finished check value, held between frames |
| crc_done | output | 1 | One-cycle pulse when `crc_out` has been updated |
| match | output | 1 | Finished value equals RESIDUE; valid with `crc_done` |

## Verification
The bench builds three instances that cover different parts of the parameter space:
- A 3-bit instance with the generator x^3+x+1 and no options. It reproduces a hand-worked long division bit by bit in serial mode.
- A 16-bit instance with polynomial 0x1021, an all-ones seed and no reflection. It covers MSB-first byte order, a zero residue, the idle and seed-only `start` paths, and sensitivity to leading zeros.
- A 32-bit instance with both reflections, an all-ones final mask and byte swap. It brings the LSB-first order, the non-zero residue and the swapped output into reach, and its width allows every burst length from 1 to 32 bits to be injected at three codeword positions.

// File: rtl/crc_engine.sv
`timescale 1ns/1ps
module crc_engine #(
  parameter int              WIDTH     = 32,
  parameter logic [WIDTH-1:0] POLY     = 'h04C11DB7,
  parameter logic [WIDTH-1:0] PRESET   = '1,
  parameter bit              REFIN     = 1'b1,
  parameter bit              REFOUT    = 1'b1,
  parameter logic [WIDTH-1:0] XOROUT   = '1,
  parameter bit              BYTE_SWAP = 1'b0,
  parameter logic [WIDTH-1:0] RESIDUE  = 'h2144DF1C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             valid,
  input  logic             byte_en,
  input  logic [7:0]       data_in,
  input  logic             last,
  output logic [WIDTH-1:0] crc_out,
  output logic             crc_done,
  output logic             match
);

  localparam int NBYTES  = WIDTH / 8;
  localparam bit SWAP_OK = BYTE_SWAP && (WIDTH % 8 == 0) && (WIDTH > 8);

  function automatic logic [WIDTH-1:0] shift_bit(input logic [WIDTH-1:0] r, input logic b);
    logic [WIDTH-1:0] n;
    n = r << 1;
    if (r[WIDTH-1] ^ b) n = n ^ POLY;
    return n;
  endfunction

  function automatic logic [WIDTH-1:0] shift_byte(input logic [WIDTH-1:0] r, input logic [7:0] d);
    logic [WIDTH-1:0] n;
    n = r;
    for (int i = 0; i < 8; i++) n = shift_bit(n, REFIN ? d[i] : d[7-i]);
    return n;
  endfunction

  logic [WIDTH-1:0] crc_q, seed, stepped, nxt, ordered, final_val, emitted;
  logic             closing;

  assign seed    = start ? PRESET : crc_q;
  assign stepped = byte_en ? shift_byte(seed, data_in) : shift_bit(seed, data_in[0]);
  assign nxt     = valid ? stepped : seed;
  assign closing = valid && last;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) ordered[i] = REFOUT ? nxt[WIDTH-1-i] : nxt[i];
  end

  assign final_val = ordered ^ XOROUT;

  generate
    if (SWAP_OK) begin : g_swap
      for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign emitted[8*k +: 8] = final_val[WIDTH-8-8*k +: 8];
      end
    end else begin : g_plain
      assign emitted = final_val;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= PRESET;
      crc_out  <= '0;
      crc_done <= 1'b0;
      match    <= 1'b0;
    end else begin
      crc_q    <= nxt;
      crc_done <= closing;
      match    <= closing && (final_val == RESIDUE);
      if (closing) crc_out <= emitted;
    end
  end

endmodule

// File: rtl/crc_engine_chk.sv
`timescale 1ns/1ps
module crc_engine_chk #(
  parameter int              WIDTH  = 32,
  parameter logic [WIDTH-1:0] PRESET = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             valid,
  input logic [WIDTH-1:0] state,
  input logic [WIDTH-1:0] crc_out,
  input logic             crc_done,
  input logic             match
);

  // R8
  match_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> crc_done);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !crc_done |-> $stable(crc_out));

  // R3
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> (state == PRESET));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !valid) |=> $stable(state));

endmodule

bind crc_engine crc_engine_chk #(.WIDTH(WIDTH), .PRESET(PRESET)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .state(crc_q),
  .crc_out(crc_out), .crc_done(crc_done), .match(match)
);

// File: tb/crc_engine_tb.sv
`timescale 1ns/1ps
module crc_engine_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic       start_s = 1'b0, valid_s = 1'b0, be_s = 1'b0, last_s = 1'b0;
  logic [7:0] data_s = 8'h00;
  int         sel = 0;

  logic [31:0] d_crc;  logic d_done, d_match;
  logic [15:0] c_crc;  logic c_done, c_match;
  logic [2:0]  t_crc;  logic t_done, t_match;

  crc_engine #(.WIDTH(32), .POLY(32'h04C11DB7), .PRESET(32'hFFFFFFFF), .REFIN(1'b1),
               .REFOUT(1'b1), .XOROUT(32'hFFFFFFFF), .BYTE_SWAP(1'b1), .RESIDUE(32'h2144DF1C)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_s && sel == 0), .valid(valid_s && sel == 0),
    .byte_en(be_s), .data_in(data_s), .last(last_s),
    .crc_out(d_crc), .crc_done(d_done), .match(d_match));

  crc_engine #(.WIDTH(16), .POLY(16'h1021), .PRESET(16'hFFFF), .REFIN(1'b0),
               .REFOUT(1'b0), .XOROUT(16'h0000), .BYTE_SWAP(1'b0), .RESIDUE(16'h0000)) u_ccitt (
    .clk(clk), .rst_n(rst_n), .start(start_s && sel == 1), .valid(valid_s && sel == 1),
    .byte_en(be_s), .data_in(data_s), .last(last_s),
    .crc_out(c_crc), .crc_done(c_done), .match(c_match));

  crc_engine #(.WIDTH(3), .POLY(3'b011), .PRESET(3'b000), .REFIN(1'b0),
               .REFOUT(1'b0), .XOROUT(3'b000), .BYTE_SWAP(1'b0), .RESIDUE(3'b000)) u_tiny (
    .clk(clk), .rst_n(rst_n), .start(start_s && sel == 2), .valid(valid_s && sel == 2),
    .byte_en(be_s), .data_in(data_s), .last(last_s),
    .crc_out(t_crc), .crc_done(t_done), .match(t_match));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref32(input logic [7:0] m[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (m[i]) begin
      c ^= {24'd0, m[i]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [15:0] ref16(input logic [7:0] m[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (m[i]) begin
      c ^= {m[i], 8'd0};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic beat(input logic st, input logic be, input logic [7:0] d, input logic lst);
    start_s = st; valid_s = 1'b1; be_s = be; data_s = d; last_s = lst;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start_s = 1'b0; valid_s = 1'b0; last_s = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bytes(input int s, input logic [7:0] m[$], input bit serial,
                            input bit lsb_first, input bit use_start);
    sel = s;
    for (int i = 0; i < m.size(); i++) begin
      if (!serial) beat(use_start && i == 0, 1'b1, m[i], i == m.size() - 1);
      else
        for (int j = 0; j < 8; j++)
          beat(use_start && i == 0 && j == 0, 1'b0, {7'd0, lsb_first ? m[i][j] : m[i][7-j]},
               i == m.size() - 1 && j == 7);
    end
    idle(0);
  endtask

  task automatic send_bits(input logic b[$]);
    sel = 2;
    for (int i = 0; i < b.size(); i++) beat(i == 0, 1'b0, {7'd0, b[i]}, i == b.size() - 1);
    idle(0);
  endtask

  logic [31:0] exp_crc_q[$];
  logic        exp_m_q[$];
  string       exp_tag_q[$];

  task automatic dut_frame(input logic [7:0] m[$], input bit serial, input logic [31:0] ec,
                           input logic em, input string tag);
    exp_crc_q.push_back(ec); exp_m_q.push_back(em); exp_tag_q.push_back(tag);
    send_bytes(0, m, serial, 1'b1, 1'b1);
  endtask

  always @(negedge clk) begin
    if (rst_n && d_done) begin
      if (exp_crc_q.size() == 0) chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
      else begin
        logic [31:0] ec; logic em; string tg;
        ec = exp_crc_q.pop_front(); em = exp_m_q.pop_front(); tg = exp_tag_q.pop_front();
        chk(d_crc == ec, {tg, " crc_out"}, d_crc, ec);
        chk(d_match == em, {tg, " match"}, {31'd0, d_match}, {31'd0, em});
      end
    end
  end

  task automatic report;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] m9[$];
    logic [7:0] m[$];
    logic [7:0] cw[$];
    logic [31:0] r;
    logic [15:0] held;
    m9 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

    repeat (3) @(negedge clk);
    chk(d_crc == 0 && !d_done && !d_match, "R11 reset 32-bit", d_crc, 32'd0);
    chk(c_crc == 0 && !c_done && !c_match, "R11 reset 16-bit", {16'd0, c_crc}, 32'd0);
    chk(t_crc == 0 && !t_done && !t_match, "R11 reset 3-bit", {29'd0, t_crc}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // 32-bit reflected code through the scoreboard
    dut_frame(m9, 1'b0, 32'h2639F4CB, 1'b0, "R4 R7 byte mode check value");
    dut_frame(m9, 1'b1, 32'h2639F4CB, 1'b0, "R5 R6 serial LSB-first");
    cw = {m9, 8'h26, 8'h39, 8'hF4, 8'hCB};
    dut_frame(cw, 1'b0, swap32(32'h2144DF1C), 1'b1, "R2 residue byte mode");
    dut_frame(cw, 1'b1, swap32(32'h2144DF1C), 1'b1, "R2 R6 residue serial");
    for (int k = 0; k < 5; k++) begin
      m = {};
      for (int i = 0; i < 1 + 3 * k; i++) m.push_back(8'(8'hA5 ^ (i * 37 + k * 11)));
      r = ref32(m);
      dut_frame(m, k[0], swap32(r), 1'b0, "R1 R5 varied message");
      cw = {m, r[7:0], r[15:8], r[23:16], r[31:24]};
      dut_frame(cw, 1'b0, swap32(32'h2144DF1C), 1'b1, "R2 varied codeword");
    end

    // R9 bursts of every length 1..32 at three positions
    m = '{8'h12, 8'h9C, 8'h00, 8'hFF, 8'h5A, 8'h33, 8'hE1, 8'h07};
    r = ref32(m);
    for (int p = 0; p < 3; p++)
      for (int len = 1; len <= 32; len++)
        for (int pat = 0; pat < 2; pat++) begin
          int pos;
          pos = (p == 0) ? 0 : (p == 1) ? 30 : 64;
          cw = {m, r[7:0], r[15:8], r[23:16], r[31:24]};
          for (int b = pos; b < pos + len; b++)
            if (pat == 0 || b == pos || b == pos + len - 1) cw[b / 8][b % 8] = ~cw[b / 8][b % 8];
          dut_frame(cw, 1'b0, swap32(ref32(cw)), 1'b0, "R9 burst");
        end
    idle(3);
    chk(exp_crc_q.size() == 0, "R8 all frames completed", exp_crc_q.size(), 32'd0);

    // 16-bit MSB-first code, direct checks
    send_bytes(1, m9, 1'b0, 1'b0, 1'b1);
    chk(c_done && c_crc == 16'h29B1, "R1 R5 16-bit byte mode", {16'd0, c_crc}, 32'h29B1);
    held = c_crc;
    @(negedge clk);
    chk(!c_done && c_crc == held, "R8 done pulse and hold", {15'd0, c_done, c_crc}, {16'd0, held});
    send_bytes(1, m9, 1'b1, 1'b0, 1'b1);
    chk(c_done && c_crc == 16'h29B1, "R6 16-bit serial MSB-first", {16'd0, c_crc}, 32'h29B1);

    sel = 1; start_s = 1'b1; valid_s = 1'b0; @(negedge clk);
    idle(3);
    chk(!c_done && c_crc == 16'h29B1, "R3 start alone emits nothing", {15'd0, c_done, c_crc}, 32'h29B1);
    send_bytes(1, m9, 1'b0, 1'b0, 1'b0);
    chk(c_done && c_crc == 16'h29B1, "R3 seed from bare start and idle", {16'd0, c_crc}, 32'h29B1);

    m = {8'h00, m9};
    send_bytes(1, m, 1'b0, 1'b0, 1'b1);
    chk(c_crc != 16'h29B1 && c_crc == ref16(m), "R10 leading zero changes result",
        {16'd0, c_crc}, {16'd0, ref16(m)});

    cw = {m9, 8'h29, 8'hB1};
    send_bytes(1, cw, 1'b0, 1'b0, 1'b1);
    chk(c_match && c_crc == 16'h0000, "R2 16-bit zero residue", {15'd0, c_match, c_crc}, 32'h10000);
    cw[4] = cw[4] ^ 8'h18;
    send_bytes(1, cw, 1'b0, 1'b0, 1'b1);
    chk(c_done && !c_match, "R9 16-bit corrupted codeword", {31'd0, c_match}, 32'd0);

    // 3-bit hand-worked division
    send_bits('{1,1,0,1,0,0,1,1,1,0,1,1,0,0});
    chk(t_done && t_crc == 3'b100, "R1 3-bit long division", {29'd0, t_crc}, 32'd4);
    send_bits('{1,1,0,1,0,0,1,1,1,0,1,1,0,0,1,0,0});
    chk(t_match && t_crc == 3'b000, "R2 3-bit zero remainder", {28'd0, t_match, t_crc}, 32'd8);

    idle(2);
    report();
  end

endmodule